// File: doc/BRIEF.md
# Modulo 2^N+1 Array Multiplier

This block multiplies two residues modulo the Fermat-style modulus 2^N+1. Both operands and the result are ordinary unsigned binary words N+1 bits wide. Every value from 0 up to and including 2^N is a legal operand, and no diminished-one or other recoding is applied on the way in or out. The default width is N = 16.

The operand value 2^N is congruent to -1, so it takes a short bypass path that negates the other operand. Operands below 2^N use the main datapath. An N-bit product matrix is built in which every bit that would land at weight 2^N or above is wrapped back to a lower weight. The wrapped bits enter inverted, and one precomputed constant row balances them. A linear carry-save array of full adders then reduces the rows. Its top carries wrap end-around, again inverted. A single carry-propagate adder and a small decrement correction produce the residue in the range 0..2^N.

A parameter selects the output timing. With the output register enabled, the result and a valid flag appear one clock after the inputs. Without it, the path is purely combinational and the valid flag follows the input flag directly.

Top module: `modf_mul`

## Requirements
- R1: With operands a and b in 0..2^N, the result p equals (a*b) mod (2^N+1), in plain binary.
- R2: The result never exceeds 2^N.
- R3: When either operand is 0, the result is 0.
- R4: Bit N of an operand marks the value 2^N, which is treated as -1. If exactly one operand equals 2^N and the other is v, the result is (2^N+1-v) mod (2^N+1). For example, 2^N*1 gives 2^N.
- R5: 2^N times 2^N gives 1.
- R6: When one operand is 1, the result equals the other operand.
- R7: A product congruent to -1 from operands below 2^N returns 2^N through the end-around correction. For example, 2*2^(N-1) gives 2^N, and (2^N-1)*(2^N-1) gives 4.
- R8: With REG_OUT=1, p and out_vld show the values for the inputs sampled at the previous rising clk edge. out_vld is a copy of in_vld. With REG_OUT=0, p is combinational and out_vld equals in_vld.
- R9: While rst_n is low (asynchronous, active low), the registered variant holds out_vld at 0 and p at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands are valid this cycle |
| a | input | N+1 | First operand, 0..2^N |
| b | input | N+1 | Second operand, 0..2^N |
| out_vld | output | 1 | Result valid |
| p | output | N+1 | Residue (a*b) mod (2^N+1) |

## Verification
On every valid transfer, the assertions check the result range and the cases that have a closed form: a zero operand, an operand of 1, one operand equal to 2^N, and both operands equal to 2^N. In the registered variant they also check the one-cycle relation between in_vld and out_vld. Only the bench's scenarios can show general products that match the modular reference, in particular the wrap-around of the carry-save array and the decrement correction that yields 2^N. The bench also covers the corner set {0, 1, 2^N-1, 2^N} crossed exhaustively, and the reset values.

// File: rtl/modf_mul.sv
module modf_mul #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [N:0]   a,
  input  logic [N:0]   b,
  output logic         out_vld,
  output logic [N:0]   p
);
  localparam logic [N:0]   MODV  = {1'b1, {(N-1){1'b0}}, 1'b1};
  localparam logic [N:0]   TOP   = {1'b1, {N{1'b0}}};
  localparam logic [N-1:0] KROW  = N'(3);

  wire [N-1:0] x = a[N-1:0];
  wire [N-1:0] y = b[N-1:0];

  logic [N-1:0] row [0:N];
  logic [N-1:0] sv  [0:N-1];
  logic [N-1:0] cv  [0:N-1];

  // product rows: wrapped bits inverted, offset balanced by KROW
  assign row[0] = y[0] ? x : '0;
  assign row[N] = KROW;
  for (genvar i = 1; i < N; i++) begin : g_row
    assign row[i] = y[i] ? {x[N-1-i:0], ~x[N-1:N-i]}
                         : {{(N-i){1'b0}}, {i{1'b1}}};
  end

  // linear carry-save array, top carry wrapped end-around inverted
  assign sv[0] = row[0];
  assign cv[0] = row[1];
  for (genvar k = 0; k < N-1; k++) begin : g_csa
    logic [N-1:0] cy;
    assign sv[k+1] = sv[k] ^ cv[k] ^ row[k+2];
    assign cy      = (sv[k] & cv[k]) | (sv[k] & row[k+2]) | (cv[k] & row[k+2]);
    assign cv[k+1] = {cy[N-2:0], ~cy[N-1]};
  end

  // carry-propagate add and end-around correction
  logic [N:0]   cpa;
  logic [N-1:0] low;
  logic [N:0]   core;
  assign cpa  = {1'b0, sv[N-1]} + {1'b0, cv[N-1]};
  assign low  = cpa[N-1:0];
  assign core = !cpa[N] ? {1'b0, low}
              : (low == '0) ? TOP
              : {1'b0, low - N'(1)};

  // operand 2^N acts as -1
  logic [N:0] res;
  always_comb begin
    if (a[N] && b[N])      res = (N+1)'(1);
    else if (a[N])         res = (b == '0) ? '0 : MODV - b;
    else if (b[N])         res = (a == '0) ? '0 : MODV - a;
    else                   res = core;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_vld <= 1'b0;
        p       <= '0;
      end else begin
        out_vld <= in_vld;
        p       <= res;
      end
    end
  end else begin : g_comb
    assign out_vld = in_vld;
    assign p       = res;
  end
endmodule

// File: rtl/modf_mul_chk.sv
module modf_mul_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_vld,
  input logic [N:0] a,
  input logic [N:0] b,
  input logic       out_vld,
  input logic [N:0] p
);
  localparam logic [N:0] MODV = {1'b1, {(N-1){1'b0}}, 1'b1};
  localparam logic [N:0] TOP  = {1'b1, {N{1'b0}}};

  AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> p <= TOP); // R2

  if (REG_OUT) begin : g_seq
    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && (a == '0 || b == '0) |=> p == '0); // R3
    AST_NEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == TOP && b != TOP && b != '0 |=> p == MODV - $past(b)); // R4
    AST_TOP_SQ: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == TOP && b == TOP |=> p == (N+1)'(1)); // R5
    AST_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == (N+1)'(1) |=> p == $past(b)); // R6
    AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R8
    AST_VLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R8
  end else begin : g_cmb
    AST_ZERO_OPND: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && (a == '0 || b == '0) |-> p == '0); // R3
    AST_NEG_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == TOP && b != TOP && b != '0 |-> p == MODV - b); // R4
    AST_TOP_SQ: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == TOP && b == TOP |-> p == (N+1)'(1)); // R5
    AST_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && a == (N+1)'(1) |-> p == b); // R6
  end
endmodule

bind modf_mul modf_mul_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
  .out_vld(out_vld), .p(p)
);

// File: tb/test_modf_mul.sv
module test_modf_mul;
  localparam int N = 16;
  localparam longint MODL = (64'd1 << N) + 1;
  localparam longint TOPL = 64'd1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [N:0] a = '0, b = '0;
  logic out_vld, out_vld_c;
  logic [N:0] p, p_c;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  modf_mul #(.N(N), .REG_OUT(1'b1)) i_modf_mul (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
    .out_vld(out_vld), .p(p));

  modf_mul #(.N(N), .REG_OUT(1'b0)) i_modf_mul_c (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
    .out_vld(out_vld_c), .p(p_c));

  function automatic longint ref_mul(longint x, longint y);
    return (x * y) % MODL;
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drives one product, checks the combinational and the registered copy
  task automatic apply(longint x, longint y, string req);
    longint e;
    e = ref_mul(x, y);
    @(negedge clk);
    a = (N+1)'(x); b = (N+1)'(y); in_vld = 1'b1;
    #1;
    check({req, " comb"}, p_c, e);
    check({req, " R8 comb vld"}, out_vld_c, 1);
    @(negedge clk);
    check({req, " reg"}, p, e);
    check({req, " R8 reg vld"}, out_vld, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 vld in reset", out_vld, 0);
    check("R9 p in reset", p, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 vld after reset", out_vld, 0);
  endtask

  task automatic t_corners;
    longint cv [4] = '{0, 1, TOPL - 1, TOPL};
    foreach (cv[i]) foreach (cv[j]) apply(cv[i], cv[j], "R1 corner");
  endtask

  task automatic t_special;
    apply(0, 12345, "R3 zero a");
    apply(777, 0, "R3 zero b");
    apply(TOPL, 5, "R4 neg a");
    apply(40000, TOPL, "R4 neg b");
    apply(TOPL, 1, "R4 top*1");
    check("R4 top*1 value", p, TOPL);
    apply(TOPL, TOPL, "R5 top sq");
    check("R5 value", p, 1);
    apply(1, 54321, "R6 unit a");
    apply(9999, 1, "R6 unit b");
  endtask

  task automatic t_wrap;
    apply(2, TOPL / 2, "R7 minus one");
    check("R7 value 2^N", p, TOPL);
    apply(TOPL - 1, TOPL - 1, "R7 square");
    check("R7 value 4", p, 4);
    apply(3, 21845, "R7 3*(2^N-1)/3");
  endtask

  task automatic t_bubble;
    @(negedge clk);
    in_vld = 1'b0;
    #1;
    check("R8 comb idle", out_vld_c, 0);
    @(negedge clk);
    check("R8 reg idle", out_vld, 0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 2000; n++) begin
      longint x = longint'($urandom % MODL);
      longint y = longint'($urandom % MODL);
      apply(x, y, "R1 random");
      total++;
      if (p > TOPL) begin
        bad++;
        $display("FAIL R2 act=%0d exp<=%0d", p, TOPL);
      end
    end
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_corners();
        t_special();
        t_wrap();
        t_bubble();
        t_random();
      end
      begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule